// File: doc/BRIEF.md
# Compare Timer

A bus-programmed timer built around an up-counter with one output-compare channel. The counter is fed by one of several tick sources and then by a programmable divider. The sources are the bus clock itself, a peripheral tick enable and a crystal tick enable. The crystal source has a divider of its own ahead of the shared one. When a count step lands on the compare value, a sticky match flag is raised. Software clears that flag by writing a one to it. The flag, gated by an enable bit, drives a registered interrupt line.

Software sets a compare value and chooses one of two behaviours on a match. In free-run mode the counter keeps going and wraps through zero. In restart mode the counter goes back to zero on the step after the match, which gives a periodic event every compare+1 steps. Tick inputs are single-cycle enables in the bus clock domain. Every register update and the interrupt output change only on the rising bus clock edge.

Top module: `ctmr_timer`

## Requirements
- R1: Register offsets are 0x00 control, 0x04 divider, 0x08 status, 0x0C interrupt enable, 0x10 compare and 0x24 count. Control keeps only bit 0 (run), bit 3 (stay on in wait), bits 8:6 (source), bit 9 (free-run) and bit 10 (crystal path on), so it keeps mask 0x7C9. The divider register keeps bits 15:0. Interrupt enable keeps bit 0. Compare keeps the counter width. The count register ignores writes. Any unmapped offset reads zero.
- R2: After reset, every register reads zero and the interrupt output is low.
- R3: Source code 1 advances the divider chain on every bus clock, and code 2 on each peripheral tick. Code 5 advances it on each crystal tick, but only while control bit 10 is set. Every other code produces no count steps.
- R4: The divider field in bits 11:0 produces one count step per field+1 source ticks.
- R5: The crystal field in bits 15:12 passes one tick per field+1 crystal ticks to the shared divider, for example 7 gives divide-by-8. It has an effect only with source code 5.
- R6: With bit 9 set, the counter keeps counting past a match and wraps from all ones to zero.
- R7: With bit 9 clear, a count step taken while the counter equals compare loads zero.
- R8: Status bit 0 is set on the clock edge where a count step makes the counter equal to compare, and it stays set. Writing a one to it clears it, writing a zero has no effect, and a set in the same cycle beats the clear.
- R9: The interrupt output equals status bit 0 AND enable bit 0 as sampled one bus clock earlier.
- R10: While control bit 0 is clear, the counter and both divider states are held at zero.
- R11: Writing compare leaves the counter value unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_per | input | 1 | Peripheral tick enable |
| tick_xtal | input | 1 | Crystal tick enable |
| bus_addr | input | ADDR_W | Register byte offset |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| irq | output | 1 | Registered compare interrupt |

## Verification
Wrong divider or source state shows up as a count value that drifts away from the reference within one divider period. The comparison on the count register catches it on the first misplaced step. A wrong match flag shows at the status offset in the cycle after the edge, and on irq one cycle after that. Restart mode and the W1C/set collision are covered by running a short compare period while software writes clear requests back to back. The reference model tracks every cycle, so any divergence is reported in the cycle where it first appears.

// File: rtl/ctmr_pkg.sv
package ctmr_pkg;
   localparam int OFF_CTRL = 'h00;
   localparam int OFF_DIV  = 'h04;
   localparam int OFF_STAT = 'h08;
   localparam int OFF_IEN  = 'h0C;
   localparam int OFF_CMP  = 'h10;
   localparam int OFF_CNT  = 'h24;

   localparam int CB_RUN   = 0;
   localparam int CB_SRC   = 6;
   localparam int CB_FREE  = 9;
   localparam int CB_XON   = 10;
   localparam logic [31:0] CTRL_KEEP = 32'h0000_07C9;

   typedef enum logic [2:0] {
      SRC_BUS  = 3'd1,
      SRC_PER  = 3'd2,
      SRC_XTAL = 3'd5
   } src_e;
endpackage

// File: rtl/ctmr_tick_sel.sv
module ctmr_tick_sel import ctmr_pkg::*; #(
   parameter int XDIV_W = 4,
   localparam int XW = (XDIV_W > 0) ? XDIV_W : 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          en,
   input  logic [2:0]    src,
   input  logic          xtal_on,
   input  logic          tick_per,
   input  logic          tick_xtal,
   input  logic [XW-1:0] xdiv,
   output logic          sel_tick
);
   logic xpulse;
   logic xin;

   assign xin = en && xtal_on && tick_xtal && (src == SRC_XTAL);

   generate
      if (XDIV_W > 0) begin : g_xdiv
         logic [XW-1:0] xc_q;
         assign xpulse = xin && (xc_q >= xdiv);
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)       xc_q <= '0;
            else if (!en)     xc_q <= '0;
            else if (xpulse)  xc_q <= '0;
            else if (xin)     xc_q <= xc_q + 1'b1;
         end
      end else begin : g_noxdiv
         assign xpulse = xin;
      end
   endgenerate

   always_comb begin
      sel_tick = 1'b0;
      if (en) begin
         case (src)
            SRC_BUS:  sel_tick = 1'b1;
            SRC_PER:  sel_tick = tick_per;
            SRC_XTAL: sel_tick = xpulse;
            default:  sel_tick = 1'b0;
         endcase
      end
   end
endmodule

// File: rtl/ctmr_prescaler.sv
module ctmr_prescaler #(
   parameter int PRE_W = 12
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic             tick_in,
   input  logic [PRE_W-1:0] div,
   output logic             step
);
   logic [PRE_W-1:0] pc_q;

   assign step = en && tick_in && (pc_q >= div);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        pc_q <= '0;
      else if (!en)      pc_q <= '0;
      else if (step)     pc_q <= '0;
      else if (tick_in)  pc_q <= pc_q + 1'b1;
   end
endmodule

// File: rtl/ctmr_counter.sv
module ctmr_counter #(
   parameter int CNT_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic             step,
   input  logic             freerun,
   input  logic [CNT_W-1:0] cmp,
   output logic [CNT_W-1:0] cnt,
   output logic             hit
);
   logic [CNT_W-1:0] nxt;

   assign nxt = (!freerun && (cnt == cmp)) ? '0 : cnt + 1'b1;
   assign hit = en && step && (nxt == cmp);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     cnt <= '0;
      else if (!en)   cnt <= '0;
      else if (step)  cnt <= nxt;
   end
endmodule

// File: rtl/ctmr_timer.sv
module ctmr_timer import ctmr_pkg::*; #(
   parameter int ADDR_W = 6,
   parameter int CNT_W  = 32,
   parameter int PRE_W  = 12,
   parameter int XDIV_W = 4,
   localparam int XW    = (XDIV_W > 0) ? XDIV_W : 1,
   localparam int DIV_W = PRE_W + XW
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick_per,
   input  logic              tick_xtal,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_we,
   input  logic [31:0]       bus_wdata,
   output logic [31:0]       bus_rdata,
   output logic              irq
);
   generate
      if (CNT_W < 1 || CNT_W > 32) begin : g_bad_cnt
         $error("ctmr_timer: CNT_W must be 1..32");
      end
      if (PRE_W < 1 || DIV_W > 32) begin : g_bad_div
         $error("ctmr_timer: PRE_W + XDIV_W must fit 32 bits");
      end
      if (ADDR_W < 6) begin : g_bad_addr
         $error("ctmr_timer: ADDR_W too small for the map");
      end
   endgenerate

   logic [31:0]      ctrl_q;
   logic [DIV_W-1:0] div_q;
   logic [CNT_W-1:0] cmp_q;
   logic             ie_q;
   logic             status_q;
   logic             sel_tick;
   logic             step;
   logic             hit;
   logic [CNT_W-1:0] cnt;
   logic             run;
   logic             wr_ctrl, wr_div, wr_ien, cmp_wr, st_w1c;

   assign run     = ctrl_q[CB_RUN];
   assign wr_ctrl = bus_we && (bus_addr == ADDR_W'(OFF_CTRL));
   assign wr_div  = bus_we && (bus_addr == ADDR_W'(OFF_DIV));
   assign wr_ien  = bus_we && (bus_addr == ADDR_W'(OFF_IEN));
   assign cmp_wr  = bus_we && (bus_addr == ADDR_W'(OFF_CMP));
   assign st_w1c  = bus_we && (bus_addr == ADDR_W'(OFF_STAT)) && bus_wdata[0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q <= '0;
         div_q  <= '0;
         cmp_q  <= '0;
         ie_q   <= 1'b0;
      end else begin
         if (wr_ctrl) ctrl_q <= bus_wdata & CTRL_KEEP;
         if (wr_div)  div_q  <= bus_wdata[DIV_W-1:0];
         if (wr_ien)  ie_q   <= bus_wdata[0];
         if (cmp_wr)  cmp_q  <= bus_wdata[CNT_W-1:0];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         status_q <= 1'b0;
         irq      <= 1'b0;
      end else begin
         irq <= status_q & ie_q;
         if (hit)         status_q <= 1'b1;
         else if (st_w1c) status_q <= 1'b0;
      end
   end

   ctmr_tick_sel #(.XDIV_W(XDIV_W)) u_sel (
      .clk      (clk),
      .rst_n    (rst_n),
      .en       (run),
      .src      (ctrl_q[CB_SRC +: 3]),
      .xtal_on  (ctrl_q[CB_XON]),
      .tick_per (tick_per),
      .tick_xtal(tick_xtal),
      .xdiv     (div_q[PRE_W +: XW]),
      .sel_tick (sel_tick)
   );

   ctmr_prescaler #(.PRE_W(PRE_W)) u_pre (
      .clk    (clk),
      .rst_n  (rst_n),
      .en     (run),
      .tick_in(sel_tick),
      .div    (div_q[PRE_W-1:0]),
      .step   (step)
   );

   ctmr_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk    (clk),
      .rst_n  (rst_n),
      .en     (run),
      .step   (step),
      .freerun(ctrl_q[CB_FREE]),
      .cmp    (cmp_q),
      .cnt    (cnt),
      .hit    (hit)
   );

   always_comb begin
      case (bus_addr)
         ADDR_W'(OFF_CTRL): bus_rdata = ctrl_q;
         ADDR_W'(OFF_DIV):  bus_rdata = 32'(div_q);
         ADDR_W'(OFF_STAT): bus_rdata = {31'b0, status_q};
         ADDR_W'(OFF_IEN):  bus_rdata = {31'b0, ie_q};
         ADDR_W'(OFF_CMP):  bus_rdata = 32'(cmp_q);
         ADDR_W'(OFF_CNT):  bus_rdata = 32'(cnt);
         default:           bus_rdata = '0;
      endcase
   end
endmodule

// File: rtl/ctmr_chk.sv
module ctmr_chk #(
   parameter int CNT_W = 32
) (
   input logic             clk,
   input logic             rst_n,
   input logic             en,
   input logic [CNT_W-1:0] cnt,
   input logic             status,
   input logic             ie,
   input logic             irq,
   input logic             w1c,
   input logic             hit,
   input logic             step,
   input logic             cmp_wr
);
   // R10
   hold_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> (cnt == '0));

   // R9
   irq_lag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (irq == $past(status & ie)));

   // R8
   sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (status && !w1c) |=> status);

   // R8
   w1c_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (status && w1c && !hit) |=> !status);

   // R6
   single_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (en && $past(en)) |-> (cnt == $past(cnt) || cnt == CNT_W'($past(cnt) + 1'b1) || cnt == '0));

   // R11
   cmp_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cmp_wr && en && !step) |=> (cnt == $past(cnt)));
endmodule

bind ctmr_timer ctmr_chk #(.CNT_W(CNT_W)) u_chk (
   .clk   (clk),
   .rst_n (rst_n),
   .en    (run),
   .cnt   (cnt),
   .status(status_q),
   .ie    (ie_q),
   .irq   (irq),
   .w1c   (st_w1c),
   .hit   (hit),
   .step  (step),
   .cmp_wr(cmp_wr)
);

// File: tb/test_ctmr_timer.sv
module test_ctmr_timer;
   localparam int CW = 16;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        tick_per = 1'b0;
   logic        tick_xtal = 1'b0;
   logic [5:0]  bus_addr = 6'h24;
   logic        bus_we = 1'b0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        irq;

   int    checks = 0;
   int    failures = 0;
   bit    done = 0;
   string cur_req = "R2";

   always #5 clk = ~clk;

   ctmr_timer #(.ADDR_W(6), .CNT_W(CW), .PRE_W(12), .XDIV_W(4)) i_ctmr_timer (
      .clk(clk), .rst_n(rst_n), .tick_per(tick_per), .tick_xtal(tick_xtal),
      .bus_addr(bus_addr), .bus_we(bus_we), .bus_wdata(bus_wdata),
      .bus_rdata(bus_rdata), .irq(irq)
   );

   // behavioural reference
   logic [31:0]   m_ctrl;
   logic [15:0]   m_div;
   logic [CW-1:0] m_cmp, m_cnt;
   logic          m_st, m_ie, m_irq;
   int            m_xc, m_pc;

   always @(posedge clk or negedge rst_n) begin : model
      bit sel, stp, landed;
      logic [CW-1:0] nxt;
      if (!rst_n) begin
         m_ctrl = 0; m_div = 0; m_cmp = 0; m_cnt = 0;
         m_st = 0; m_ie = 0; m_irq = 0; m_xc = 0; m_pc = 0;
      end else begin
         sel = 0; stp = 0; landed = 0; nxt = m_cnt;
         if (m_ctrl[0]) begin
            if (m_ctrl[8:6] == 3'd1) sel = 1;
            else if (m_ctrl[8:6] == 3'd2) sel = tick_per;
            else if (m_ctrl[8:6] == 3'd5 && m_ctrl[10] && tick_xtal) begin
               if (m_xc >= int'(m_div[15:12])) begin m_xc = 0; sel = 1; end
               else m_xc = m_xc + 1;
            end
            if (sel) begin
               if (m_pc >= int'(m_div[11:0])) begin m_pc = 0; stp = 1; end
               else m_pc = m_pc + 1;
            end
            if (stp) begin
               nxt = (!m_ctrl[9] && m_cnt == m_cmp) ? '0 : m_cnt + 1'b1;
               landed = (nxt == m_cmp);
            end
         end else begin
            m_xc = 0; m_pc = 0; nxt = '0;
         end
         m_irq = m_st & m_ie;
         if (landed) m_st = 1;
         else if (bus_we && bus_addr == 6'h08 && bus_wdata[0]) m_st = 0;
         m_cnt = nxt;
         if (bus_we) begin
            if (bus_addr == 6'h00) m_ctrl = bus_wdata & 32'h7C9;
            if (bus_addr == 6'h04) m_div  = bus_wdata[15:0];
            if (bus_addr == 6'h0C) m_ie   = bus_wdata[0];
            if (bus_addr == 6'h10) m_cmp  = bus_wdata[CW-1:0];
         end
      end
   end

   function automatic logic [31:0] exp_rd(logic [5:0] a);
      case (a)
         6'h00: return m_ctrl;
         6'h04: return {16'b0, m_div};
         6'h08: return {31'b0, m_st};
         6'h0C: return {31'b0, m_ie};
         6'h10: return 32'(m_cmp);
         6'h24: return 32'(m_cnt);
         default: return 32'h0;
      endcase
   endfunction

   task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string req, input string what);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s %s actual=%h expected=%h t=%0t", req, what, act, exp, $time);
      end
   endtask

   always @(negedge clk) begin
      if (rst_n && !done) begin
         chk(bus_rdata, exp_rd(bus_addr), cur_req, "rdata");
         chk({31'b0, irq}, {31'b0, m_irq}, "R9", "irq");
      end
   end

   always @(posedge clk) begin
      #1;
      tick_per  = ($urandom % 2) == 0;
      tick_xtal = ($urandom % 3) == 0;
   end

   task automatic wr(input logic [5:0] a, input logic [31:0] d);
      @(posedge clk); #1;
      bus_we = 1; bus_addr = a; bus_wdata = d;
      @(posedge clk); #1;
      bus_we = 0; bus_addr = 6'h24;
   endtask

   task automatic expect_rd(input logic [5:0] a, input logic [31:0] e, input string req);
      @(posedge clk); #1;
      bus_addr = a;
      @(negedge clk);
      chk(bus_rdata, e, req, "fixed");
      #1 bus_addr = 6'h24;
   endtask

   task automatic idle(input int n);
      repeat (n) @(posedge clk);
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      if (!done) begin
         failures++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      idle(4);
      #1 rst_n = 1;
      // R2 reset state
      cur_req = "R2";
      expect_rd(6'h00, 0, "R2"); expect_rd(6'h04, 0, "R2"); expect_rd(6'h08, 0, "R2");
      expect_rd(6'h0C, 0, "R2"); expect_rd(6'h10, 0, "R2"); expect_rd(6'h24, 0, "R2");
      chk({31'b0, irq}, 32'h0, "R2", "irq");
      // R1 map and masks
      cur_req = "R1";
      wr(6'h00, 32'hFFFF_FFFF); expect_rd(6'h00, 32'h7C9, "R1");
      wr(6'h04, 32'hFFFF_FFFF); expect_rd(6'h04, 32'hFFFF, "R1");
      wr(6'h0C, 32'h3);         expect_rd(6'h0C, 32'h1, "R1");
      wr(6'h10, 32'h1234_5678); expect_rd(6'h10, 32'h5678, "R1");
      wr(6'h24, 32'hABCD);      expect_rd(6'h24, 32'h0, "R1");
      expect_rd(6'h14, 32'h0, "R1");
      wr(6'h00, 0); wr(6'h04, 0); wr(6'h0C, 0);
      // R3 sources
      cur_req = "R3";
      wr(6'h10, 32'h8000);
      wr(6'h00, 32'h241); idle(30);
      wr(6'h00, 32'h281); idle(60);
      wr(6'h00, 32'h341); idle(30);
      wr(6'h00, 32'h741); idle(40);
      wr(6'h00, 32'h2C1); idle(30);
      // R5 crystal divider
      cur_req = "R5";
      wr(6'h00, 32'h741); wr(6'h04, 32'h2000); idle(60);
      wr(6'h04, 32'h7001); idle(120);
      wr(6'h00, 32'h281); idle(40);
      // R4 main divider
      cur_req = "R4";
      wr(6'h04, 32'h3); wr(6'h00, 32'h241); idle(50);
      wr(6'h04, 32'h2); wr(6'h00, 32'h281); idle(60);
      // R10 stop holds zero
      cur_req = "R10";
      wr(6'h00, 32'h240); idle(10);
      expect_rd(6'h24, 32'h0, "R10");
      // R7 restart mode, R9 interrupt gating
      cur_req = "R7";
      wr(6'h04, 32'h1); wr(6'h10, 32'h5); wr(6'h0C, 1);
      wr(6'h00, 32'h041); idle(40);
      wr(6'h08, 0); idle(5);
      wr(6'h08, 1); idle(20);
      cur_req = "R9";
      wr(6'h0C, 0); idle(20); wr(6'h08, 1); wr(6'h0C, 1); idle(30);
      // R11 compare write while running
      cur_req = "R11";
      wr(6'h04, 32'h3); wr(6'h10, 32'h9); idle(7); wr(6'h10, 32'h4); idle(40);
      // R8 clear/set collisions
      cur_req = "R8";
      wr(6'h04, 0); wr(6'h10, 32'h2);
      for (int k = 0; k < 8; k++) wr(6'h08, 1);
      idle(10);
      // R6 free-run wrap
      cur_req = "R6";
      wr(6'h00, 0); wr(6'h10, 32'h10); wr(6'h08, 1);
      wr(6'h00, 32'h241);
      idle(65536 + 60);
      wr(6'h08, 1); idle(10);
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule